// File: doc/BRIEF.md
# Scanline-Emulating Interrupt Counter

This block is an 8-bit up-counter that reloads from a software-set latch and raises a level interrupt request each time it rolls over from its top value. It counts in one of two modes. In cycle mode it advances on every CPU cycle strobe. In scanline mode a prescaler stands in for a display line: each CPU cycle takes 3 off a period of 341, and the counter advances whenever that period runs out.

The CPU reaches the block through four decoded sub-registers: latch low nibble, latch high nibble, control and acknowledge. A one-cycle `cpu_tick` strobe marks each CPU cycle. The address decode from the full bus sits outside the block. The interrupt line stays high until software writes control or acknowledge.

Top module: `line_irq_timer`

## Requirements
- R1: After reset `irq` is 0, and the control byte, latch and count are all zero. The prescaler holds 341. A control write of 0x06 with no latch writes first makes `irq` rise on the 256th tick.
- R2: A write with `wr_sel`=0 sets latch bits [3:0] from `wr_data[3:0]`. A write with `wr_sel`=1 sets latch bits [7:4] from `wr_data[3:0]`. The upper data bits are ignored.
- R3: A write with `wr_sel`=2 stores `wr_data` as the control byte. When bit 1 (run) of that byte is 1, the count loads from the latch and the prescaler returns to 341.
- R4: Any write with `wr_sel`=2 or `wr_sel`=3 drops `irq` to 0 on the next cycle.
- R5: A write with `wr_sel`=3 copies control bit 0 (rearm) into control bit 1 (run) and leaves every other control bit unchanged. While run is 0, ticks do not move the count.
- R6: When run is 1 and control bit 2 (cycle mode) is 1, every `cpu_tick` advances the count by one.
- R7: When run is 1 and cycle mode is 0, every `cpu_tick` takes 3 from the prescaler. If the result is 0 or less, 341 is added back and the count advances. From a fresh load, the count advances after 114, 114 and 113 ticks, and then this pattern repeats.
- R8: When the count advances from 0xFF, it reloads from the latch instead of wrapping to 0, and `irq` becomes 1 on the next cycle.
- R9: `irq` stays at 1 through idle cycles, further ticks and latch writes, until a write with `wr_sel`=2 or 3.
- R10: A `cpu_tick` in the same cycle as a write with `wr_sel`=2 or 3 is discarded. It moves neither the count nor the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Decoded register write strobe |
| wr_sel | input | 2 | Sub-register select: 0 latch low, 1 latch high, 2 control, 3 acknowledge |
| wr_data | input | 8 | Write data |
| cpu_tick | input | 1 | One pulse per CPU cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- an interrupt rises only after a rollover and always after one;
- it holds until a control or acknowledge write, and such a write always clears it;
- acknowledge copies rearm into run and discards the count step;
- a control write with run set loads the count and the prescaler;
- the prescaler stays between -2 and 341;
- cycle mode steps the count once per tick.

The 114/114/113 scanline cadence, the assembled latch value, and the ticks lost to a write collision only show up as the exact cycle on which `irq` rises. The bench scenarios pin those cycles down against a reference model that tracks elapsed dots rather than a falling prescaler.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
  typedef enum logic [1:0] {
    REG_LATCH_LO = 2'd0,
    REG_LATCH_HI = 2'd1,
    REG_CTRL     = 2'd2,
    REG_ACK      = 2'd3
  } reg_sel_e;

  localparam int BIT_REARM    = 0;
  localparam int BIT_RUN      = 1;
  localparam int BIT_CPU_MODE = 2;
endpackage

// File: rtl/line_irq_regs.sv
module line_irq_regs
  import line_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  latch,
  output logic [DATA_W-1:0] ctrl,
  output logic              ctrl_load,
  output logic              irq_clr
);
  localparam int HALF = CNT_W / 2;
  localparam int UPW  = CNT_W - HALF;

  logic wr_lo, wr_hi, wr_ctrl, wr_ack;

  assign wr_lo     = wr_en && (wr_sel == REG_LATCH_LO);
  assign wr_hi     = wr_en && (wr_sel == REG_LATCH_HI);
  assign wr_ctrl   = wr_en && (wr_sel == REG_CTRL);
  assign wr_ack    = wr_en && (wr_sel == REG_ACK);
  assign ctrl_load = wr_ctrl && wr_data[BIT_RUN];
  assign irq_clr   = wr_ctrl || wr_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch <= '0;
    end else if (wr_lo) begin
      latch[HALF-1:0] <= wr_data[HALF-1:0];
    end else if (wr_hi) begin
      latch[CNT_W-1:HALF] <= wr_data[UPW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl <= wr_data;
    end else if (wr_ack) begin
      ctrl[BIT_RUN] <= ctrl[BIT_REARM];
    end
  end
endmodule

// File: rtl/line_irq_prescaler.sv
module line_irq_prescaler #(
  parameter int PERIOD = 341,
  parameter int STEP   = 3,
  parameter int PRE_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reload,
  input  logic                    step_en,
  output logic signed [PRE_W-1:0] presc,
  output logic                    line_evt
);
  localparam logic signed [PRE_W-1:0] PER_S  = PRE_W'(PERIOD);
  localparam logic signed [PRE_W-1:0] STEP_S = PRE_W'(STEP);

  function automatic logic signed [PRE_W-1:0] dec(input logic signed [PRE_W-1:0] v);
    return v - STEP_S;
  endfunction

  function automatic logic expired(input logic signed [PRE_W-1:0] v);
    return v[PRE_W-1] || (v == '0);
  endfunction

  logic signed [PRE_W-1:0] nxt;

  assign nxt      = dec(presc);
  assign line_evt = step_en && !reload && expired(nxt);

  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      presc <= PER_S;
    end else if (step_en) begin
      presc <= expired(nxt) ? nxt + PER_S : nxt;
    end
  end
endmodule

// File: rtl/line_irq_count.sv
module line_irq_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             cnt_step,
  input  logic             irq_clr,
  input  logic [CNT_W-1:0] latch,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             irq
);
  assign wrap_evt = cnt_step && !load && (count == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load || wrap_evt) begin
      count <= latch;
    end else if (cnt_step) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (wrap_evt) begin
      irq <= 1'b1;
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer
  import line_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int PERIOD = 341,
  parameter int STEP   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_tick,
  output logic              irq
);
  localparam int PRE_W = $clog2(PERIOD + 1) + 1;

  logic [CNT_W-1:0]        latch;
  logic [CNT_W-1:0]        count;
  logic [DATA_W-1:0]       ctrl;
  logic                    ctrl_load, irq_clr;
  logic signed [PRE_W-1:0] presc;
  logic                    line_evt, wrap_evt;
  logic                    tick_ok, cnt_step, presc_step;

  // control/ack writes own the cycle; a coincident tick is discarded
  assign tick_ok    = cpu_tick && ctrl[BIT_RUN] && !irq_clr;
  assign presc_step = tick_ok && !ctrl[BIT_CPU_MODE];
  assign cnt_step   = tick_ok && (ctrl[BIT_CPU_MODE] || line_evt);

  line_irq_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .latch(latch), .ctrl(ctrl), .ctrl_load(ctrl_load), .irq_clr(irq_clr)
  );

  line_irq_prescaler #(.PERIOD(PERIOD), .STEP(STEP), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .reload(ctrl_load), .step_en(presc_step),
    .presc(presc), .line_evt(line_evt)
  );

  line_irq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(ctrl_load), .cnt_step(cnt_step),
    .irq_clr(irq_clr), .latch(latch), .count(count), .wrap_evt(wrap_evt), .irq(irq)
  );
endmodule

// File: rtl/line_irq_chk.sv
module line_irq_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8,
  parameter int PERIOD = 341,
  parameter int STEP   = 3,
  parameter int PRE_W  = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [1:0]              wr_sel,
  input logic [DATA_W-1:0]       wr_data,
  input logic                    cpu_tick,
  input logic                    irq,
  input logic [DATA_W-1:0]       ctrl,
  input logic [CNT_W-1:0]        latch,
  input logic [CNT_W-1:0]        count,
  input logic signed [PRE_W-1:0] presc,
  input logic                    wrap_evt
);
  localparam logic signed [PRE_W-1:0] PER_S = PRE_W'(PERIOD);
  localparam logic signed [PRE_W-1:0] LOW_S = PRE_W'(1 - STEP);

  logic clr_wr;
  assign clr_wr = wr_en && wr_sel[1];

  // R4
  clr_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !irq);
  // R8
  wrap_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> irq);
  // R8
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(wrap_evt));
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);
  // R5
  ack_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> (ctrl[1] == $past(ctrl[0])) && (ctrl[0] == $past(ctrl[0]))
      && (ctrl[DATA_W-1:2] == $past(ctrl[DATA_W-1:2])));
  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[1]) |=> (count == $past(latch)) && (presc == PER_S)
      && (ctrl == $past(wr_data)));
  // R7
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (presc >= LOW_S) && (presc <= PER_S));
  // R6
  cyc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_tick && ctrl[1] && ctrl[2] && !wr_en && count != '1) |=> count == $past(count) + 1'b1);
  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> (count == $past(count)) && (presc == $past(presc)));
endmodule

bind line_irq_timer line_irq_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .PERIOD(PERIOD), .STEP(STEP), .PRE_W(PRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cpu_tick(cpu_tick), .irq(irq), .ctrl(ctrl), .latch(latch), .count(count),
  .presc(presc), .wrap_evt(wrap_evt)
);

// File: tb/sim_line_irq_timer.sv
`timescale 1ns/1ps
module sim_line_irq_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       cpu_tick = 1'b0;
  logic       irq;

  always #2.5 clk = ~clk;

  line_irq_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq)
  );

  typedef struct { logic irq; string tag; } exp_t;
  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model: tracks dots elapsed in the current line
  logic [7:0] m_latch = 0, m_ctrl = 0, m_cnt = 0;
  logic       m_irq = 0;
  int         m_dots = 0;

  task automatic model(input logic we, input logic [1:0] sel, input logic [7:0] d, input logic tk);
    bit fire;
    if (tk && !(we && sel >= 2) && m_ctrl[1]) begin
      fire = 1'b1;
      if (!m_ctrl[2]) begin
        m_dots += 3;
        fire = (m_dots >= 341);
        if (fire) m_dots -= 341;
      end
      if (fire) begin
        if (m_cnt == 8'hFF) begin m_cnt = m_latch; m_irq = 1'b1; end
        else m_cnt = m_cnt + 8'd1;
      end
    end
    if (we) begin
      case (sel)
        2'd0: m_latch[3:0] = d[3:0];
        2'd1: m_latch[7:4] = d[3:0];
        2'd2: begin
          m_ctrl = d; m_irq = 1'b0;
          if (d[1]) begin m_cnt = m_latch; m_dots = 0; end
        end
        default: begin m_ctrl[1] = m_ctrl[0]; m_irq = 1'b0; end
      endcase
    end
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [7:0] d, input logic tk);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; cpu_tick = tk;
    @(posedge clk);
    model(we, sel, d, tk);
    e.irq = m_irq; e.tag = cur_tag;
    q.push_back(e);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'd0, 1'b0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    cyc(1'b1, sel, d, 1'b0);
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (irq !== e.irq) begin
          errors++;
          $display("FAIL %s: irq=%0b expected %0b at %0t", e.tag, irq, e.irq, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(posedge clk);
    e.irq = 1'b0; e.tag = "R1 reset";
    q.push_back(e);
    @(negedge clk); rst_n = 1'b1;

    cur_tag = "R1"; idle(2);
    wr(2'd2, 8'h06);                     // R1: latch still zero, count 0
    cur_tag = "R1 R8"; ticks(260);

    cur_tag = "R4"; wr(2'd2, 8'h06);

    cur_tag = "R2"; wr(2'd0, 8'hAB); wr(2'd1, 8'h3F);   // latch 0xFB
    wr(2'd2, 8'h06);
    cur_tag = "R2 R6 R8"; ticks(7);

    cur_tag = "R9"; idle(5); ticks(10); wr(2'd0, 8'h0B); idle(3);

    cur_tag = "R5"; wr(2'd2, 8'h05); ticks(300);         // run off
    wr(2'd3, 8'h00);                                      // run <= rearm=1
    cur_tag = "R5 R6"; ticks(260);
    cur_tag = "R5"; wr(2'd2, 8'h04); wr(2'd3, 8'h00); ticks(300);

    cur_tag = "R10"; wr(2'd2, 8'h07); ticks(3);
    cyc(1'b1, 2'd3, 8'h00, 1'b1);                         // tick dropped
    ticks(3);
    cyc(1'b1, 2'd2, 8'h05, 1'b1); ticks(2);               // dropped, run off

    cur_tag = "R7"; wr(2'd0, 8'h0E); wr(2'd1, 8'h0F);     // latch 0xFE
    wr(2'd2, 8'h02); ticks(600);
    cur_tag = "R3"; wr(2'd2, 8'h02); ticks(50);
    wr(2'd2, 8'h02); ticks(230);

    cur_tag = "R7 R8"; wr(2'd0, 8'h0F);                   // latch 0xFF
    wr(2'd2, 8'h03);
    for (int k = 0; k < 10; k++) begin
      ticks(120); wr(2'd3, 8'h00);
    end

    idle(3);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule